// File: doc/BRIEF.md
# Command/Address Parity Checker with Shared Error Alert

This block sits in the command/address input path of a DDR4-style memory device. On each rising clock edge where the chip select is active, it takes the sampled command and address word and the parity input. It checks that the word has even parity. A mode enable turns the check on and off.

The first parity failure starts a recovery window. The block raises a busy handshake toward the device's internal recovery logic and holds the alert low. It releases the alert only after a minimum low time has passed and the recovery logic reports completion. While the window is open, commands are flagged to be dropped.

A write-CRC error reported from elsewhere drives the same active-low alert, but only for a short fixed pulse. A sticky flag and a snapshot of the failing word stay available until a clear input removes them.

There is no streaming data path. Every pin is a plain level or single-cycle control, so no valid/ready back-pressure applies. The chip select qualifies the command word in the cycle it is low.

Top module: `ca_par_alert`

## Requirements
- R1: After the asynchronous active-low reset, and at once while reset is held, `alert_n` is 1, `rec_busy` is 0, `par_err_flag` is 0 and `err_word` is 0.
- R2: A parity failure is flagged only at a rising edge where `par_en` is 1 and `cs_n` is 0. Otherwise a bad parity has no effect on any output.
- R3: The checked word is {cid[2:0], act_n, bg[1:0], ba[1:0], addr[17:0]}, with cid at bits 25:23, act_n at bit 22, bg at 21:20, ba at 19:18 and addr at 17:0. A failure is when the XOR of all its bits and `par_in` is 1.
- R4: From the cycle after a first failure, `alert_n` is 0, `rec_busy` is 1, `par_err_flag` is 1 and `err_word` holds the failing word.
- R5: `cmd_ignore` is 1 during a cycle whose command fails parity, and during every cycle in which `rec_busy` is 1.
- R6: The parity alert stays low for at least PAR_LOW cycles. It is released at the first edge where PAR_LOW low cycles have elapsed and `rec_done` is 1. With `rec_done` held at 1 it lasts exactly PAR_LOW cycles.
- R7: A failing command during recovery neither extends the window nor changes `err_word`.
- R8: `crc_err` sampled high at an edge drives `alert_n` low for exactly CRC_LOW cycles, starting with the next cycle. A new `crc_err` reloads the pulse. A CRC error leaves `par_err_flag` and `rec_busy` untouched.
- R9: When a CRC pulse and a parity window overlap, `alert_n` stays low until the later of the two releases.
- R10: `clr` clears `par_err_flag` and `err_word`. If a new first failure arrives in the same cycle, the capture wins.
- R11: When CID_EN is 0, the cid inputs are left out of the parity and read back as 0 in `err_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_en | input | 1 | Mode enable for the parity check |
| cs_n | input | 1 | Active-low chip select qualifying the command |
| act_n | input | 1 | Activate command pin |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank address |
| addr | input | 18 | Address; bits 16:14 double as command pins |
| cid | input | 3 | Stacked-die chip ID |
| par_in | input | 1 | Even-parity bit for the command word |
| crc_err | input | 1 | Write-CRC error strobe |
| rec_done | input | 1 | Recovery logic reports completion |
| clr | input | 1 | Clears the sticky flag and captured word |
| alert_n | output | 1 | Active-low shared error alert |
| cmd_ignore | output | 1 | Current command should be dropped |
| rec_busy | output | 1 | Parity recovery in progress |
| par_err_flag | output | 1 | Sticky parity-error status |
| err_word | output | 26 | Snapshot of the first failing command word |

## Verification
A recovery state machine stuck busy shows at the ports as `alert_n` pinned low and `cmd_ignore` high. This is seen one window length after `rec_done` rises. A state machine that drops out early shows a low time shorter than PAR_LOW, measured cycle by cycle.

A wrong parity fold or a wrong bit mapping is exposed within one cycle by a walking-one sweep over all 26 word bits, in both good and bad parity. A capture that fires during recovery shows as a changed `err_word` on the next cycle. A CRC counter that is off by one shows as a pulse length other than CRC_LOW.

// File: rtl/ca_par_pkg.sv
package ca_par_pkg;
  typedef enum logic {
    REC_IDLE = 1'b0,
    REC_WAIT = 1'b1
  } rec_state_e;

  localparam int CID_MAX_W = 3;

  function automatic int ca_word_width(input int addr_w, input int bg_w, input int ba_w);
    return CID_MAX_W + 1 + bg_w + ba_w + addr_w;
  endfunction
endpackage

// File: rtl/ca_par_check.sv
module ca_par_check #(
  parameter int ADDR_W = 18,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter bit CID_EN = 1'b1,
  parameter int CA_W   = ca_par_pkg::ca_word_width(ADDR_W, BG_W, BA_W)
) (
  input  logic                            par_en,
  input  logic                            cs_n,
  input  logic                            act_n,
  input  logic [BG_W-1:0]                 bg,
  input  logic [BA_W-1:0]                 ba,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [ca_par_pkg::CID_MAX_W-1:0] cid,
  input  logic                            par_in,
  output logic [CA_W-1:0]                 word,
  output logic                            fail
);
  localparam int CW = ca_par_pkg::CID_MAX_W;

  logic [CW-1:0] cid_used;

  generate
    if (CID_EN) begin : g_cid
      assign cid_used = cid;
    end else begin : g_nocid
      assign cid_used = '0;
    end
  endgenerate

  assign word = {cid_used, act_n, bg, ba, addr};
  // even parity: all covered bits plus the parity bit must fold to zero
  assign fail = par_en & ~cs_n & ((^word) ^ par_in);
endmodule

// File: rtl/ca_crc_pulse.sv
module ca_crc_pulse #(
  parameter int CRC_LOW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crc_err,
  output logic active
);
  localparam int CW = $clog2(CRC_LOW + 1);
  localparam logic [CW-1:0] LOAD = CW'(CRC_LOW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (crc_err) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);

  a_r8_crc_load: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> active);
  a_r8_crc_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && !crc_err) |=> !active);
endmodule

// File: rtl/ca_par_recovery.sv
module ca_par_recovery #(
  parameter int CA_W    = 26,
  parameter int PAR_LOW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fail,
  input  logic [CA_W-1:0] word,
  input  logic            rec_done,
  input  logic            clr,
  output logic            busy,
  output logic            sticky,
  output logic [CA_W-1:0] err_word
);
  import ca_par_pkg::*;

  localparam int TW = $clog2(PAR_LOW + 1);
  localparam logic [TW-1:0] LAST = TW'(PAR_LOW - 1);

  rec_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic          capture;

  assign capture = fail && (state_q == REC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= REC_IDLE;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        REC_IDLE: begin
          if (fail) begin
            state_q <= REC_WAIT;
            tmr_q   <= '0;
          end
        end
        REC_WAIT: begin
          if (tmr_q == LAST && rec_done) begin
            state_q <= REC_IDLE;
          end else if (tmr_q != LAST) begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= REC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky   <= 1'b0;
      err_word <= '0;
    end else if (capture) begin
      sticky   <= 1'b1;
      err_word <= word;
    end else if (clr) begin
      sticky   <= 1'b0;
      err_word <= '0;
    end
  end

  assign busy = (state_q == REC_WAIT);

  a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !busy) |=> (busy && sticky));
  a_r6_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rec_done) |=> busy);
  a_r6_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr_q != LAST) |=> busy);
  a_r7_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail && !clr) |=> $stable(err_word));
endmodule

// File: rtl/ca_par_alert.sv
module ca_par_alert #(
  parameter int ADDR_W  = 18,
  parameter int BG_W    = 2,
  parameter int BA_W    = 2,
  parameter bit CID_EN  = 1'b1,
  parameter int CRC_LOW = 6,
  parameter int PAR_LOW = 64,
  localparam int CA_W   = ca_par_pkg::ca_word_width(ADDR_W, BG_W, BA_W)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             par_en,
  input  logic                             cs_n,
  input  logic                             act_n,
  input  logic [BG_W-1:0]                  bg,
  input  logic [BA_W-1:0]                  ba,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [ca_par_pkg::CID_MAX_W-1:0] cid,
  input  logic                             par_in,
  input  logic                             crc_err,
  input  logic                             rec_done,
  input  logic                             clr,
  output logic                             alert_n,
  output logic                             cmd_ignore,
  output logic                             rec_busy,
  output logic                             par_err_flag,
  output logic [CA_W-1:0]                  err_word
);
  logic [CA_W-1:0] word;
  logic            fail;
  logic            crc_act;

  ca_par_check #(
    .ADDR_W(ADDR_W), .BG_W(BG_W), .BA_W(BA_W), .CID_EN(CID_EN), .CA_W(CA_W)
  ) u_check (
    .par_en(par_en), .cs_n(cs_n), .act_n(act_n), .bg(bg), .ba(ba),
    .addr(addr), .cid(cid), .par_in(par_in), .word(word), .fail(fail)
  );

  ca_par_recovery #(
    .CA_W(CA_W), .PAR_LOW(PAR_LOW)
  ) u_rec (
    .clk(clk), .rst_n(rst_n), .fail(fail), .word(word), .rec_done(rec_done),
    .clr(clr), .busy(rec_busy), .sticky(par_err_flag), .err_word(err_word)
  );

  ca_crc_pulse #(
    .CRC_LOW(CRC_LOW)
  ) u_crc (
    .clk(clk), .rst_n(rst_n), .crc_err(crc_err), .active(crc_act)
  );

  assign alert_n    = ~(rec_busy | crc_act);
  assign cmd_ignore = rec_busy | fail;

  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_busy) |-> $past(par_en && !cs_n));
  a_r8_crc_alert: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> !alert_n);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fail) |=> !par_err_flag);
  a_r8_crc_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !fail && !par_err_flag) |=> !par_err_flag);
endmodule

// File: tb/ca_par_alert_tb_top.sv
module ca_par_alert_tb_top;
  localparam int PL = 8;
  localparam int CL = 3;
  localparam int W  = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_en = 1'b1, cs_n = 1'b1, act_n = 1'b1, par_in = 1'b0;
  logic [1:0] bg = '0, ba = '0;
  logic [17:0] addr = '0;
  logic [2:0] cid = '0;
  logic crc_err = 1'b0, rec_done = 1'b1, clr = 1'b0;
  logic alert_n, cmd_ignore, rec_busy, par_err_flag;
  logic [W-1:0] err_word;
  logic nc_alert_n, nc_ignore, nc_busy, nc_flag;
  logic [W-1:0] nc_word;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ca_par_alert #(.CRC_LOW(CL), .PAR_LOW(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .par_en(par_en), .cs_n(cs_n), .act_n(act_n),
    .bg(bg), .ba(ba), .addr(addr), .cid(cid), .par_in(par_in),
    .crc_err(crc_err), .rec_done(rec_done), .clr(clr), .alert_n(alert_n),
    .cmd_ignore(cmd_ignore), .rec_busy(rec_busy), .par_err_flag(par_err_flag),
    .err_word(err_word));

  ca_par_alert #(.CID_EN(1'b0), .CRC_LOW(CL), .PAR_LOW(PL)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .par_en(par_en), .cs_n(cs_n), .act_n(act_n),
    .bg(bg), .ba(ba), .addr(addr), .cid(cid), .par_in(par_in),
    .crc_err(crc_err), .rec_done(rec_done), .clr(clr), .alert_n(nc_alert_n),
    .cmd_ignore(nc_ignore), .rec_busy(nc_busy), .par_err_flag(nc_flag),
    .err_word(nc_word));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ones_at(input int b);
    logic [W-1:0] v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  // drive one command word at the falling edge, then sample after the rising edge
  task automatic step(input logic [W-1:0] w, input bit sel, input bit badp,
                      input bit crc, input bit clr_i, output bit ign_pre);
    @(negedge clk);
    {cid, act_n, bg, ba, addr} = w;
    cs_n = ~sel;
    par_in = (^w) ^ badp;
    crc_err = crc;
    clr = clr_i;
    #1 ign_pre = cmd_ignore;
    @(posedge clk);
    #1;
  endtask

  // counts consecutive low alert cycles starting with the current one
  task automatic count_low(input int crc_at, input int bad_at, output int n);
    int k = 0;
    n = 0;
    while (!alert_n && k < 500) begin
      n++;
      k++;
      @(negedge clk);
      clr = 1'b0;
      crc_err = (k == crc_at);
      if (k == bad_at) begin
        {cid, act_n, bg, ba, addr} = 26'h0AAA;
        par_in = ~(^26'h0AAA);
        cs_n = 1'b0;
      end else begin
        cs_n = 1'b1;
      end
      @(posedge clk);
      #1;
    end
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      cs_n = 1'b1; crc_err = 1'b0; clr = 1'b0;
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ig;
    int n;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(alert_n && !rec_busy && !par_err_flag && err_word == '0, "R1 reset state",
        {alert_n, rec_busy, par_err_flag}, 3'b100);
    rst_n = 1'b1;
    idle(2);

    // R2 disabled check ignores bad parity
    par_en = 1'b0;
    step(26'h1234, 1, 1, 0, 0, ig);
    chk(alert_n && !par_err_flag && !ig, "R2 disabled", alert_n, 1);
    par_en = 1'b1;
    // R2 deselected cycle ignored
    step(26'h1234, 0, 1, 0, 0, ig);
    chk(alert_n && !par_err_flag && !ig, "R2 cs_n high", alert_n, 1);
    idle(1);

    // R3 R4 R5 R6 walking-one sweep over every covered bit
    for (int b = 0; b < W; b++) begin
      step(ones_at(b), 1, 0, 0, 0, ig);
      chk(alert_n && !ig, $sformatf("R3 good parity bit %0d", b), alert_n, 1);
      step(ones_at(b), 1, 1, 0, 0, ig);
      chk(ig, $sformatf("R5 ignore on fail bit %0d", b), ig, 1);
      chk(!alert_n && rec_busy && par_err_flag,
          $sformatf("R4 alert low bit %0d", b), alert_n, 0);
      chk(err_word == ones_at(b), $sformatf("R3 captured word bit %0d", b),
          err_word, ones_at(b));
      chk(cmd_ignore, $sformatf("R5 ignore while busy bit %0d", b), cmd_ignore, 1);
      count_low(0, 0, n);
      chk(n == PL, $sformatf("R6 low time bit %0d", b), n, PL);
      step('0, 0, 0, 0, 1, ig);
      chk(!par_err_flag && err_word == '0, $sformatf("R10 clear bit %0d", b),
          par_err_flag, 0);
    end

    // R6 release waits on rec_done
    rec_done = 1'b0;
    step(26'h3, 1, 1, 0, 0, ig);
    idle(2 * PL);
    chk(!alert_n && rec_busy, "R6 held without rec_done", alert_n, 0);
    @(negedge clk); rec_done = 1'b1;
    @(posedge clk); #1;
    chk(alert_n && !rec_busy, "R6 release on rec_done", alert_n, 1);
    step('0, 0, 0, 0, 1, ig);

    // R7 second failure during recovery
    step(26'h5, 1, 1, 0, 0, ig);
    count_low(0, 3, n);
    chk(n == PL, "R7 no restart", n, PL);
    chk(err_word == 26'h5, "R7 word kept", err_word, 26'h5);
    step('0, 0, 0, 0, 1, ig);

    // R8 CRC pulse alone
    step('0, 0, 0, 1, 0, ig);
    chk(!par_err_flag && !rec_busy, "R8 crc leaves parity state", par_err_flag, 0);
    count_low(0, 0, n);
    chk(n == CL, "R8 crc pulse width", n, CL);
    // R8 retrigger: second strobe on the second low cycle
    step('0, 0, 0, 1, 0, ig);
    count_low(2, 0, n);
    chk(n == CL + 2, "R8 crc retrigger", n, CL + 2);

    // R9 overlap, CRC late in the parity window
    step(26'h9, 1, 1, 0, 0, ig);
    count_low(PL - 1, 0, n);
    chk(n == PL - 1 + CL, "R9 overlap later release", n, PL - 1 + CL);
    // R9 overlap, CRC early: parity governs
    step('0, 0, 0, 0, 1, ig);
    step(26'h9, 1, 1, 0, 0, ig);
    count_low(1, 0, n);
    chk(n == PL, "R9 overlap parity longer", n, PL);

    // R10 capture wins over clear
    step(26'h11, 1, 1, 0, 1, ig);
    chk(par_err_flag && err_word == 26'h11, "R10 capture beats clear", err_word, 26'h11);
    count_low(0, 0, n);
    step('0, 0, 0, 0, 1, ig);

    // R11 cid excluded when disabled
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(26'h0800000, 1, 1, 0, 0, ig);  // cid bit 23 set, parity ignores it
    chk(nc_alert_n && !nc_flag, "R11 cid ignored", nc_alert_n, 1);
    chk(!alert_n, "R11 cid counted when enabled", alert_n, 0);
    step(26'h0800001, 1, 0, 0, 0, ig);
    chk(!nc_alert_n && nc_word == 26'h1, "R11 cid reads zero", nc_word, 26'h1);

    // R1 asynchronous reset mid-alert
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk(alert_n && !rec_busy && !par_err_flag && err_word == '0, "R1 async reset",
        {alert_n, rec_busy, par_err_flag}, 3'b100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule